// File: doc/BRIEF.md
# FG Phase Comparator with Masked Lock Indicator

This block sits in the speed loop of a brushless spindle drive. It watches the rising edges of an already synchronized reference clock (at most 10 kHz) and of the speed-feedback signal taken from the first Hall sensor. It turns the time between the two edges into an up or down pulse: the pulse lasts as many clock cycles as the edges lie apart. A later analog stage filters these pulses and adjusts the drive until the feedback frequency equals the reference frequency.

Each comparison either qualifies lock or disqualifies it. A comparison qualifies lock when the two edges fall within a programmable window of cycles. A comparison disqualifies lock as soon as an open error pulse has outlasted the window. A qualified lock reaches the lock output only after it has held without a break for a programmable number of cycles. This hides the brief lock/unlock flicker that comes from hunting while the motor pulls in, and after a change of the reference frequency. A mask length of zero turns the masking off. When the run enable is low, every output is held inactive and all comparison state is cleared.

Top module: `fg_phase_lock_det`

## Requirements
- R1: While reset is active, and after reset is released before any input edge, `err_up`, `err_dn` and `lock_flag` are 0.
- R2: When a reference rising edge is sampled at clock edge e and a feedback rising edge is sampled at edge e+d (d ≥ 1), `err_up` is 1 for exactly d cycles: after edges e through e+d-1. `err_dn` stays 0.
- R3: When the feedback rising edge leads the reference rising edge by d ≥ 1 cycles, `err_dn` is 1 for exactly d cycles and `err_up` stays 0.
- R4: Rising edges sampled in the same cycle on both inputs produce no pulse. `err_up` and `err_dn` are never 1 together.
- R5: A comparison whose edge separation d is no larger than `win_len` qualifies lock. A separation larger than `win_len` disqualifies it.
- R6: An open error pulse disqualifies lock without waiting for the closing edge. With the lock output high and a pulse opened at edge e that does not close in time, `lock_flag` goes to 0 after edge e+`win_len`+2.
- R7: After a qualifying comparison closed at edge c, starting from the disqualified state, `lock_flag` becomes 1 after edge c+`mask_len`+1 and not earlier.
- R8: Any disqualification clears `lock_flag` on the next cycle and restarts the mask count from zero. A later qualifying comparison again waits the full mask length.
- R9: With `mask_len` = 0, `lock_flag` becomes 1 after edge c+1 following a qualifying comparison that closes at edge c.
- R10: With `run_en` low, `err_up`, `err_dn` and `lock_flag` are 0 after the next clock edge, and input edges cause no pulse. The input history is still tracked, so an input already high when `run_en` rises does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | 1 = run, 0 = stopped (all outputs inactive, state cleared) |
| ref_clk_in | input | 1 | Synchronized reference clock |
| fg_in | input | 1 | Speed-feedback signal from the first Hall input |
| win_len | input | CNT_W (8) | Lock window in clock cycles |
| mask_len | input | MASK_W (12) | Lock mask length in clock cycles, 0 = no masking |
| err_up | output | 1 | Phase-error pulse, reference leads |
| err_dn | output | 1 | Phase-error pulse, feedback leads |
| lock_flag | output | 1 | Masked lock indicator |

## Verification
A stale or wrong pulse-width counter shows up as a lock decision with the wrong value, or at the wrong time, at the next comparison: a separation right at the window edge, or a missing feedback edge that does not drop lock exactly `win_len`+2 cycles after the pulse opens. A mask counter that keeps its count across a disqualification makes `lock_flag` rise earlier than `mask_len`+1 cycles after the closing edge. It therefore shows on the very first re-lock. A PFD latch that fails to clear leaves `err_up` or `err_dn` high one cycle too long, which the pulse-width sweep catches on every separation it drives.

// File: rtl/fgpc_pkg.sv
package fgpc_pkg;
    localparam int PULSE_CNT_W = 8;
    localparam int MASK_CNT_W  = 12;

    typedef struct packed {
        logic up;
        logic dn;
    } phase_err_t;
endpackage

// File: rtl/fgpc_edge_pfd.sv
module fgpc_edge_pfd
    import fgpc_pkg::*;
#(
    parameter int CNT_W = PULSE_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             ref_in,
    input  logic             fg_in,
    output phase_err_t       err,
    output logic             active,
    output logic             close_evt,
    output logic [CNT_W:0]   sep,
    output logic [CNT_W-1:0] width_cnt
);
    typedef struct packed {
        logic             ref_h;
        logic             fg_h;
        logic             up;
        logic             dn;
        logic [CNT_W-1:0] cnt;
    } pfd_st_t;

    pfd_st_t s_d, s_q;
    logic    ref_rise, fg_rise, up_n, dn_n, busy_q;

    always_comb begin
        s_d       = s_q;
        ref_rise  = ref_in & ~s_q.ref_h;
        fg_rise   = fg_in & ~s_q.fg_h;
        busy_q    = s_q.up | s_q.dn;
        up_n      = s_q.up | ref_rise;
        dn_n      = s_q.dn | fg_rise;
        close_evt = run_en & up_n & dn_n;
        sep       = busy_q ? ({1'b0, s_q.cnt} + 1'b1) : '0;

        s_d.ref_h = ref_in;
        s_d.fg_h  = fg_in;
        if (close_evt) begin
            s_d.up = 1'b0;
            s_d.dn = 1'b0;
        end else begin
            s_d.up = up_n;
            s_d.dn = dn_n;
        end
        if (!busy_q) begin
            s_d.cnt = '0;
        end else if (!(&s_q.cnt)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (!run_en) begin
            s_d.up  = 1'b0;
            s_d.dn  = 1'b0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign err.up    = s_q.up;
    assign err.dn    = s_q.dn;
    assign active    = busy_q;
    assign width_cnt = s_q.cnt;
endmodule

// File: rtl/fgpc_lock_eval.sv
module fgpc_lock_eval
    import fgpc_pkg::*;
#(
    parameter int CNT_W = PULSE_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             close_evt,
    input  logic             active,
    input  logic [CNT_W:0]   sep,
    input  logic [CNT_W-1:0] width_cnt,
    input  logic [CNT_W-1:0] win_len,
    output logic             raw_lock
);
    typedef struct packed {
        logic qual;
    } eval_st_t;

    eval_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run_en) begin
            s_d.qual = 1'b0;
        end else if (close_evt) begin
            s_d.qual = (sep <= {1'b0, win_len});
        end else if (active && (width_cnt >= win_len)) begin
            s_d.qual = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign raw_lock = s_q.qual;
endmodule

// File: rtl/fgpc_lock_mask.sv
module fgpc_lock_mask
    import fgpc_pkg::*;
#(
    parameter int MASK_W = MASK_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              raw_lock,
    input  logic [MASK_W-1:0] mask_len,
    output logic              lock_out
);
    typedef struct packed {
        logic [MASK_W-1:0] cnt;
        logic              lock;
    } mask_st_t;

    mask_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run_en || !raw_lock) begin
            s_d.cnt  = '0;
            s_d.lock = 1'b0;
        end else if (s_q.cnt >= mask_len) begin
            s_d.lock = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lock_out = s_q.lock;
endmodule

// File: rtl/fg_phase_lock_det.sv
module fg_phase_lock_det
    import fgpc_pkg::*;
#(
    parameter int CNT_W  = PULSE_CNT_W,
    parameter int MASK_W = MASK_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              ref_clk_in,
    input  logic              fg_in,
    input  logic [CNT_W-1:0]  win_len,
    input  logic [MASK_W-1:0] mask_len,
    output logic              err_up,
    output logic              err_dn,
    output logic              lock_flag
);
    phase_err_t       err;
    logic             pulse_active;
    logic             close_evt;
    logic             raw_lock;
    logic [CNT_W:0]   sep;
    logic [CNT_W-1:0] pulse_width;

    fgpc_edge_pfd #(.CNT_W(CNT_W)) u_pfd (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .ref_in    (ref_clk_in),
        .fg_in     (fg_in),
        .err       (err),
        .active    (pulse_active),
        .close_evt (close_evt),
        .sep       (sep),
        .width_cnt (pulse_width)
    );

    fgpc_lock_eval #(.CNT_W(CNT_W)) u_eval (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .close_evt (close_evt),
        .active    (pulse_active),
        .sep       (sep),
        .width_cnt (pulse_width),
        .win_len   (win_len),
        .raw_lock  (raw_lock)
    );

    fgpc_lock_mask #(.MASK_W(MASK_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .raw_lock (raw_lock),
        .mask_len (mask_len),
        .lock_out (lock_flag)
    );

    assign err_up = err.up;
    assign err_dn = err.dn;
endmodule

// File: rtl/fg_phase_lock_det_chk.sv
module fg_phase_lock_det_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             ref_clk_in,
    input logic             fg_in,
    input logic             err_up,
    input logic             err_dn,
    input logic             lock_flag,
    input logic             raw_lock,
    input logic             pulse_active,
    input logic [CNT_W-1:0] pulse_width,
    input logic [CNT_W-1:0] win_len
);
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_up && err_dn));

    assert_up_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_up) |-> $past(ref_clk_in));

    assert_dn_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_dn) |-> $past(fg_in));

    assert_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_active && (pulse_width >= win_len)) |=> !raw_lock);

    assert_lock_needs_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag |-> $past(raw_lock));

    assert_loss_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_lock |=> !lock_flag);

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!err_up && !err_dn && !lock_flag));
endmodule

bind fg_phase_lock_det fg_phase_lock_det_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .ref_clk_in   (ref_clk_in),
    .fg_in        (fg_in),
    .err_up       (err_up),
    .err_dn       (err_dn),
    .lock_flag    (lock_flag),
    .raw_lock     (raw_lock),
    .pulse_active (pulse_active),
    .pulse_width  (pulse_width),
    .win_len      (win_len)
);

// File: tb/fg_phase_lock_det_test.sv
module fg_phase_lock_det_test;
    localparam int CW = 8;
    localparam int MW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          ref_clk_in = 1'b0;
    logic          fg_in = 1'b0;
    logic [CW-1:0] win_len = '0;
    logic [MW-1:0] mask_len = '0;
    logic          err_up, err_dn, lock_flag;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    fg_phase_lock_det #(.CNT_W(CW), .MASK_W(MW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .ref_clk_in (ref_clk_in),
        .fg_in      (fg_in),
        .win_len    (win_len),
        .mask_len   (mask_len),
        .err_up     (err_up),
        .err_dn     (err_dn),
        .lock_flag  (lock_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drop both inputs, then raise the leader; the follower rises d cycles later.
    // Negedge k follows the clock edge e+k-1, where e samples the leader.
    task automatic do_pair(input bit ref_first, input int d, input int nwatch,
                           output int up_w, output int dn_w,
                           output int first_lk, output int drop_k);
        ref_clk_in = 1'b0;
        fg_in      = 1'b0;
        repeat (3) @(negedge clk);
        up_w = 0; dn_w = 0; first_lk = -1; drop_k = -1;
        if (d == 0) begin
            ref_clk_in = 1'b1;
            fg_in      = 1'b1;
        end else if (ref_first) begin
            ref_clk_in = 1'b1;
        end else begin
            fg_in = 1'b1;
        end
        for (int k = 1; k <= nwatch; k++) begin
            @(negedge clk);
            if (err_up) up_w++;
            if (err_dn) dn_w++;
            if (lock_flag && first_lk < 0) first_lk = k;
            if (!lock_flag && drop_k < 0) drop_k = k;
            if (k == d) begin
                ref_clk_in = 1'b1;
                fg_in      = 1'b1;
            end
        end
    endtask

    initial begin
        int uw, dw, fl, dk;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!err_up && !err_dn && !lock_flag, "R1 during reset", {err_up, err_dn, lock_flag}, 0);
        rst_n  = 1'b1;
        run_en = 1'b1;
        repeat (3) @(negedge clk);
        check(!err_up && !err_dn && !lock_flag, "R1 after release", {err_up, err_dn, lock_flag}, 0);

        // R2 R3 R4 R5 R9: separation and window sweep, mask off
        mask_len = '0;
        for (int w = 0; w <= 4; w++) begin
            win_len = CW'(w);
            for (int d = 0; d <= 6; d++) begin
                for (int rf = 0; rf <= 1; rf++) begin
                    do_pair(rf[0], d, d + 3, uw, dw, fl, dk);
                    if (rf == 1) begin
                        check(uw == d, "R2 up width", uw, d);
                        check(dw == 0, "R2 dn silent", dw, 0);
                    end else begin
                        check(dw == d, "R3 dn width", dw, d);
                        check(uw == ((d == 0) ? 0 : 0), "R3 up silent", uw, 0);
                    end
                    if (d == 0) check(uw == 0 && dw == 0, "R4 coincident no pulse", uw + dw, 0);
                    check(lock_flag == (d <= w), "R5 window decision", lock_flag, (d <= w) ? 1 : 0);
                end
            end
        end

        // R6: open pulse drops lock at k = win+3
        for (int w = 1; w <= 5; w += 2) begin
            win_len  = CW'(w);
            mask_len = '0;
            do_pair(1'b1, 0, 3, uw, dw, fl, dk);
            check(lock_flag == 1'b1, "R6 locked before", lock_flag, 1);
            do_pair(1'b1, 20, 25, uw, dw, fl, dk);
            check(dk == w + 3, "R6 timeout drop cycle", dk, w + 3);
        end

        // R7 R9: mask delay sweep
        win_len = CW'(3);
        for (int mi = 0; mi < 4; mi++) begin
            int m;
            m = (mi == 0) ? 0 : (mi == 1) ? 1 : (mi == 2) ? 4 : 9;
            mask_len = MW'(m);
            for (int d = 0; d <= 3; d += (d == 1) ? 2 : 1) begin
                do_pair(1'b1, 8, 11, uw, dw, fl, dk);
                check(lock_flag == 1'b0, "R7 unlocked before", lock_flag, 0);
                do_pair(1'b1, d, d + m + 6, uw, dw, fl, dk);
                if (m == 0)
                    check(fl == d + 2, "R9 unmasked lock cycle", fl, d + 2);
                else
                    check(fl == d + m + 2, "R7 masked lock cycle", fl, d + m + 2);
            end
        end

        // R8: disqualification restarts the mask count
        mask_len = MW'(12);
        win_len  = CW'(3);
        do_pair(1'b1, 8, 11, uw, dw, fl, dk);
        check(lock_flag == 1'b0, "R8 unlocked start", lock_flag, 0);
        do_pair(1'b1, 1, 4, uw, dw, fl, dk);
        check(fl == -1, "R8 no early lock", fl, -1);
        do_pair(1'b0, 6, 9, uw, dw, fl, dk);
        check(fl == -1, "R8 hunting hidden", fl, -1);
        do_pair(1'b1, 2, 20, uw, dw, fl, dk);
        check(fl == 16, "R8 full mask after restart", fl, 16);
        do_pair(1'b1, 10, 13, uw, dw, fl, dk);
        check(dk == 6, "R8 drop after loss", dk, 6);

        // R10: stop behaviour
        mask_len = '0;
        do_pair(1'b1, 0, 3, uw, dw, fl, dk);
        check(lock_flag == 1'b1, "R10 locked before stop", lock_flag, 1);
        run_en = 1'b0;
        @(negedge clk);
        check(!lock_flag && !err_up && !err_dn, "R10 stop clears", {err_up, err_dn, lock_flag}, 0);
        ref_clk_in = 1'b0; fg_in = 1'b0;
        @(negedge clk);
        ref_clk_in = 1'b1;
        uw = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (err_up || lock_flag) uw++;
        end
        check(uw == 0, "R10 edges ignored when stopped", uw, 0);
        run_en = 1'b1;
        uw = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (err_up) uw++;
        end
        check(uw == 0, "R10 no false edge on restart", uw, 0);
        ref_clk_in = 1'b0;
        @(negedge clk);
        ref_clk_in = 1'b1;
        repeat (2) @(negedge clk);
        check(err_up == 1'b1, "R10 pulse open before stop", err_up, 1);
        run_en = 1'b0;
        @(negedge clk);
        check(err_up == 1'b0, "R10 stop cuts pulse", err_up, 0);
        run_en = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule